// File: doc/BRIEF.md
# Dual-Read Register File with Hardwired Zero Entry

This block is the general-purpose register bank of a load-store processor core. It holds a set of word-wide registers that the decode stage reads through two independent read ports, one per source operand, and that the write-back stage updates through a single write port. Reads are combinational: each read port returns the contents of the register its index selects, without waiting for a clock edge. A write is committed on the rising clock edge when the write enable is high. A value written in one cycle can be read only after that edge, because the block has no same-cycle forwarding.

Entry 0 is the constant-zero register. Any write aimed at it is discarded, and both read ports return zero whenever they select it. The storage is an explicit array of edge-triggered flip-flops. A write-enable-gated index decoder produces one load strobe per row, and each read port has its own wide selector. A synchronous clear brings every register to zero, so that a simulation or a bring-up sequence starts from known contents.

The default build has 32 entries of 32 bits with 5-bit indices. The parameters set the data width, the index width, and whether entry 0 is hardwired.

Top module: `dual_read_regfile`

## Requirements
- R1: The file holds 2**ADDR_W entries of DATA_W bits. By default that is 32 entries of 32 bits, indexed 0 to 31. Every entry from 1 to 31 keeps its own value independently of the others.
- R2: Reads are combinational. Within the same clock cycle, changing `rd_a_idx` or `rd_b_idx` changes the matching data output to the selected entry's contents.
- R3: Either read port returns 32'h0000_0000 whenever its index is 0.
- R4: A write with `wr_en`=1 and `wr_idx`=0 has no effect. Entry 0 still reads as zero after the edge.
- R5: While `wr_en` is 0, no entry changes on a clock edge, whatever `wr_idx` and `wr_data` carry.
- R6: When `wr_en`=1 at a rising edge, `wr_data` is stored into entry `wr_idx`. The read ports show the new value only after that edge and show the old value during the writing cycle.
- R7: A write changes only the addressed entry. At most one row load strobe is active in any cycle, and none is active while `wr_en` is 0.
- R8: The two read ports are independent. They may select different entries, or the same entry, in the same cycle, and each returns the correct contents.
- R9: `rst`=1 at a rising edge clears all entries to zero and takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst | input | 1 | Synchronous clear, active high |
| rd_a_idx | input | ADDR_W (5) | Index selected by read port A |
| rd_a_data | output | DATA_W (32) | Contents of the entry at `rd_a_idx` |
| rd_b_idx | input | ADDR_W (5) | Index selected by read port B |
| rd_b_data | output | DATA_W (32) | Contents of the entry at `rd_b_idx` |
| wr_en | input | 1 | Write enable |
| wr_idx | input | ADDR_W (5) | Index of the entry to write |
| wr_data | input | DATA_W (32) | Value to store |

## Verification
A vector table mixes several kinds of cycles: writes to fresh rows, rewrites of a live row, cycles with `wr_en` low but noisy `wr_idx` and `wr_data`, and writes aimed at entry 0. It reads each row on the same cycle as its write and again after the edge. That separates a correct edge-committed write from a forwarding path, a lost write, or a write that lands in a neighbouring row. A full fill with a per-row pattern, read back with port A ascending and port B descending, exposes decoder or selector index faults and any crossing between the two ports, including both ports on the same row. Directed cases then apply a clear that coincides with a write, so a clear that loses priority is caught, and hold `wr_en` low over several noisy cycles.

// File: rtl/rf_pkg.sv
package rf_pkg;
   localparam int RF_ADDR_W_DFLT = 5;
   localparam int RF_DATA_W_DFLT = 32;

   function automatic int rf_rows(input int addr_w);
      return 1 << addr_w;
   endfunction
endpackage

// File: rtl/rf_wr_decoder.sv
module rf_wr_decoder #(
   parameter int ADDR_W = rf_pkg::RF_ADDR_W_DFLT,
   localparam int ROWS = rf_pkg::rf_rows(ADDR_W)
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   output logic [ROWS-1:0]   row_load
);
   for (genvar g = 0; g < ROWS; g++) begin : g_row
      assign row_load[g] = wr_en && (wr_idx == ADDR_W'(g));
   end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
   parameter int ADDR_W     = rf_pkg::RF_ADDR_W_DFLT,
   parameter int DATA_W     = rf_pkg::RF_DATA_W_DFLT,
   parameter bit ZERO_ENTRY = 1'b1,
   localparam int ROWS = rf_pkg::rf_rows(ADDR_W)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [ROWS-1:0]              row_load,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [ROWS-1:0][DATA_W-1:0]  rows_q
);
   for (genvar g = 0; g < ROWS; g++) begin : g_row
      if (ZERO_ENTRY && g == 0) begin : g_const
         assign rows_q[g] = '0;
      end else begin : g_ff
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (row_load[g])
               q <= wr_data;
         end
         assign rows_q[g] = q;
      end
   end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
   parameter int ADDR_W = rf_pkg::RF_ADDR_W_DFLT,
   parameter int DATA_W = rf_pkg::RF_DATA_W_DFLT,
   localparam int ROWS = rf_pkg::rf_rows(ADDR_W)
) (
   input  logic [ROWS-1:0][DATA_W-1:0] rows_q,
   input  logic [ADDR_W-1:0]           sel,
   output logic [DATA_W-1:0]           dout
);
   always_comb begin
      dout = '0;
      for (int k = 0; k < ROWS; k++) begin
         if (sel == ADDR_W'(k))
            dout = rows_q[k];
      end
   end
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
   parameter int ADDR_W     = rf_pkg::RF_ADDR_W_DFLT,
   parameter int DATA_W     = rf_pkg::RF_DATA_W_DFLT,
   parameter bit ZERO_ENTRY = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ADDR_W-1:0] rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int ROWS = rf_pkg::rf_rows(ADDR_W);

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("dual_read_regfile: ADDR_W must lie in 1..10");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dual_read_regfile: DATA_W must be positive");
   end

   logic [ROWS-1:0]             row_load;
   logic [ROWS-1:0][DATA_W-1:0] rows_q;

   rf_wr_decoder #(.ADDR_W(ADDR_W)) u_dec (
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .row_load (row_load)
   );

   rf_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZERO_ENTRY(ZERO_ENTRY)) u_store (
      .clk      (clk),
      .rst      (rst),
      .row_load (row_load),
      .wr_data  (wr_data),
      .rows_q   (rows_q)
   );

   rf_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_a (
      .rows_q (rows_q),
      .sel    (rd_a_idx),
      .dout   (rd_a_data)
   );

   rf_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_b (
      .rows_q (rows_q),
      .sel    (rd_b_idx),
      .dout   (rd_b_data)
   );
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int ADDR_W     = rf_pkg::RF_ADDR_W_DFLT,
   parameter int DATA_W     = rf_pkg::RF_DATA_W_DFLT,
   parameter bit ZERO_ENTRY = 1'b1,
   localparam int ROWS = rf_pkg::rf_rows(ADDR_W)
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [ADDR_W-1:0] rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic [ROWS-1:0]   row_load
);
   if (ZERO_ENTRY) begin : g_zero
      p_zero_a_r3: assert property (@(posedge clk) disable iff (rst)
         (rd_a_idx == '0) |-> (rd_a_data == '0));
      p_zero_b_r3: assert property (@(posedge clk) disable iff (rst)
         (rd_b_idx == '0) |-> (rd_b_data == '0));
   end

   p_load_onehot_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(row_load));

   p_no_load_idle_r5: assert property (@(posedge clk) disable iff (rst)
      !wr_en |-> (row_load == '0));

   p_hold_a_r5: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (rd_a_idx != $past(rd_a_idx)) || (rd_a_data == $past(rd_a_data)));

   p_write_seen_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx != '0) |=>
         (rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data)));

   p_same_row_r8: assert property (@(posedge clk) disable iff (rst)
      (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

   p_clear_r9: assert property (@(posedge clk)
      rst |=> (rd_a_data == '0) && (rd_b_data == '0));
endmodule

bind dual_read_regfile rf_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZERO_ENTRY(ZERO_ENTRY)
) u_rf_chk (
   .clk       (clk),
   .rst       (rst),
   .rd_a_idx  (rd_a_idx),
   .rd_a_data (rd_a_data),
   .rd_b_idx  (rd_b_idx),
   .rd_b_data (rd_b_data),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .wr_data   (wr_data),
   .row_load  (row_load)
);

// File: tb/test_dual_read_regfile.sv
module test_dual_read_regfile;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int NV = 13;

   logic          clk = 1'b0;
   logic          rst;
   logic [AW-1:0] rd_a_idx, rd_b_idx, wr_idx;
   logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
   logic          wr_en;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   dual_read_regfile #(.ADDR_W(AW), .DATA_W(DW)) i_dual_read_regfile (
      .clk(clk), .rst(rst),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   // {we, widx, wdata, ra, rb, expected_a, expected_b}; reads sampled before the edge
   localparam logic [111:0] VEC [NV] = '{
      {1'b1, 5'd5,  32'h1111_0005, 5'd5,  5'd0,  32'h0000_0000, 32'h0000_0000}, // R6 no bypass
      {1'b1, 5'd9,  32'h9999_0009, 5'd5,  5'd9,  32'h1111_0005, 32'h0000_0000}, // R6
      {1'b0, 5'd5,  32'hDEAD_BEEF, 5'd9,  5'd5,  32'h9999_0009, 32'h1111_0005}, // R8
      {1'b1, 5'd0,  32'hFFFF_FFFF, 5'd5,  5'd5,  32'h1111_0005, 32'h1111_0005}, // R5 R8
      {1'b1, 5'd31, 32'h8000_0001, 5'd0,  5'd0,  32'h0000_0000, 32'h0000_0000}, // R4 R3
      {1'b0, 5'd31, 32'h0000_0000, 5'd31, 5'd0,  32'h8000_0001, 32'h0000_0000}, // R6
      {1'b1, 5'd5,  32'h5555_AAAA, 5'd5,  5'd31, 32'h1111_0005, 32'h8000_0001}, // R6
      {1'b1, 5'd6,  32'h0000_0006, 5'd5,  5'd9,  32'h5555_AAAA, 32'h9999_0009}, // R7
      {1'b1, 5'd6,  32'h6666_6666, 5'd6,  5'd6,  32'h0000_0006, 32'h0000_0006}, // R8
      {1'b0, 5'd0,  32'h0000_0000, 5'd6,  5'd5,  32'h6666_6666, 32'h5555_AAAA}, // R7
      {1'b1, 5'd1,  32'hFFFF_FFFF, 5'd1,  5'd2,  32'h0000_0000, 32'h0000_0000}, // R6
      {1'b1, 5'd2,  32'h0F0F_0F0F, 5'd1,  5'd2,  32'hFFFF_FFFF, 32'h0000_0000}, // R7
      {1'b0, 5'd3,  32'h7777_7777, 5'd2,  5'd1,  32'h0F0F_0F0F, 32'hFFFF_FFFF}  // R5
   };

   function automatic logic [DW-1:0] pat(input int i);
      return {8'hC3, 8'(i), 8'(~i), 8'(i * 3)};
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic          v_we;
      logic [AW-1:0] v_wi, v_ra, v_rb;
      logic [DW-1:0] v_wd, v_ea, v_eb;

      rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
      rd_a_idx = '0; rd_b_idx = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0; rd_a_idx = 5'd7; rd_b_idx = 5'd31;
      #2;
      check("R9 reset state port A", rd_a_data, '0);
      check("R9 reset state port B", rd_b_data, '0);

      for (int n = 0; n < NV; n++) begin
         @(negedge clk);
         {v_we, v_wi, v_wd, v_ra, v_rb, v_ea, v_eb} = VEC[n];
         wr_en = v_we; wr_idx = v_wi; wr_data = v_wd;
         rd_a_idx = v_ra; rd_b_idx = v_rb;
         #2;
         check($sformatf("R6/R8 vector %0d port A", n), rd_a_data, v_ea);
         check($sformatf("R6/R8 vector %0d port B", n), rd_b_data, v_eb);
      end

      // R1 fill every row, then sweep both ports in opposite directions
      for (int i = 1; i < 32; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_idx = AW'(i); wr_data = pat(i);
      end
      @(negedge clk);
      wr_en = 1'b0; wr_data = 32'hBAD0_BAD0;
      for (int i = 0; i < 32; i++) begin
         rd_a_idx = AW'(i); rd_b_idx = AW'(31 - i);
         #1;
         check($sformatf("R1/R2/R3 port A row %0d", i), rd_a_data, (i == 0) ? '0 : pat(i));
         check($sformatf("R1/R8 port B row %0d", 31 - i), rd_b_data,
               (i == 31) ? '0 : pat(31 - i));
      end

      // R4 write aimed at entry 0
      @(negedge clk);
      wr_en = 1'b1; wr_idx = '0; wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      wr_en = 1'b0; rd_a_idx = '0; rd_b_idx = '0;
      #2;
      check("R4 entry 0 port A", rd_a_data, '0);
      check("R4 entry 0 port B", rd_b_data, '0);

      // R5 noisy idle cycles leave row 12 intact
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         wr_en = 1'b0; wr_idx = 5'd12; wr_data = 32'h0BAD_0000 + c;
      end
      @(negedge clk);
      rd_a_idx = 5'd12; rd_b_idx = 5'd13;
      #2;
      check("R5 row 12 held", rd_a_data, pat(12));
      check("R5 row 13 held", rd_b_data, pat(13));

      // R9 clear wins over a simultaneous write
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b1; wr_idx = 5'd10; wr_data = 32'h1234_5678;
      @(negedge clk);
      rst = 1'b0; wr_en = 1'b0; rd_a_idx = 5'd10; rd_b_idx = 5'd20;
      #2;
      check("R9 cleared row 10", rd_a_data, '0);
      check("R9 cleared row 20", rd_b_data, '0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule